// File: doc/BRIEF.md
# Cassette FSK Tape Writer

This block copies an inclusive range of a synchronous byte memory onto a single tape line using square-wave frequency-shift keying. The line never carries a level as data. Only its level changes count, and each change closes one phase. A pulse on `start` latches a first and a last address. The block then plays a long leader tone, built from asymmetric cycles, so that a reader can lock on. A start marker follows, whose first phase is shortened. After that come the data bytes, most significant bit first, with no checksum and nothing after them.

A data bit takes one full cycle made of two equal phases. A 0 uses the short phase, which gives the higher tone. A 1 uses the long phase, which gives the lower tone. Every phase length is a parameter counted in clock cycles. The defaults target a 50 MHz clock: about 250 µs and 500 µs for the bit phases, 565 µs and 455 µs for the leader phases, 385 µs for the shortened marker phase, and about 10 s of leader. The block reads the next byte while the last bit of the current byte is still on the line. Bytes therefore follow one another with no gap.

Top module: `tape_fsk_writer`

## Requirements
- R1: After reset, `tape_out`, `busy`, `done` and `rd_en` are all 0.
- R2: A `start` pulse seen while idle raises `busy` at the same clock edge and latches both addresses. A `start` pulse seen while busy is ignored, and the transmission in progress does not change.
- R3: The first phases on the line are LEADER_CYC leader cycles. Each cycle is a phase of LEAD_LONG clocks followed by a phase of LEAD_SHORT clocks. The first phase starts at the edge that accepted `start`.
- R4: After the leader comes the start marker: one phase of MARK_SHORT clocks, then one phase of MARK_NORM clocks.
- R5: Each byte is sent as 8 bits, MSB first. A 0 bit is two phases of ZERO_PH clocks each. A 1 bit is two phases of ONE_PH clocks each.
- R6: Bytes are sent in this order: the start address, then addresses rising by one (modulo 2^ADDR_W), ending with the byte at the end address. Nothing follows that byte.
- R7: If the start address is greater than the end address, exactly one byte (the one at the start address) is sent.
- R8: Each byte is read exactly once, by a single `rd_en` cycle at that address. `rd_data` is taken in the cycle after `rd_en`. Consecutive bytes leave no gap on the line.
- R9: `done` is a one-clock pulse. It is set at the same edge as the final level change, and `busy` falls at that edge. While idle, `tape_out` holds its level.
- R10: `tape_out` changes only while a transmission runs, once per phase boundary, and never on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transmission (taken only while idle) |
| start_addr | input | ADDR_W | First address of the range |
| end_addr | input | ADDR_W | Last address of the range (inclusive) |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | DATA_W | Memory read data, valid one cycle after `rd_en` |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle pulse at the end of a transmission |
| tape_out | output | 1 | Toggle-only tape line |

## Verification
The bound checker watches properties on every clock:
- the line changes only during a transmission and never on back-to-back clocks;
- `done` is a lone pulse that coincides with `busy` falling;
- reads happen only while busy;
- an idle `start` always raises `busy`.

Some behaviour only the bench scenarios can show: the exact phase-length sequence of leader, marker and MSB-first data, the inclusive address walk, and the single-byte case for a reversed range. The same holds for the top-of-memory range and for a `start` pulse during a run being ignored. The bench shows these by measuring every interval between level changes and comparing it with a sequence computed from its own memory image.

// File: rtl/tfw_pkg.sv
// Shared types and helpers for the cassette FSK tape writer.
// Assumes nothing beyond standard SystemVerilog.
package tfw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_MARK,
        ST_DATA
    } tfw_state_e;

    // Larger of two unsigned values, used to size the phase counter.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tfw_phase_timer.sv
// Phase timer: a load starts a phase of `len` clocks, and `expire` is high in the
// last clock of that phase.
// Assumes len >= 1. A load in the expiring clock starts the next phase without a gap.
module tfw_phase_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    logic             running;

    assign expire = running && (cnt == '0);

    // Count down the remaining clocks of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= len - CNT_W'(1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tfw_fetch.sv
// Byte fetcher: walks the address range and issues one memory read per request.
// It stages the returned byte, together with a flag that says whether it is the last one.
// Assumes the memory has one cycle of read latency, and that requests are at least 2 clocks apart.
module tfw_fetch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              req,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] nxt_byte,
    output logic              nxt_last
);
    logic [ADDR_W-1:0] walk_addr;
    logic [ADDR_W-1:0] stop_addr;
    logic              pending;
    logic              pend_last;

    assign rd_en   = req;
    assign rd_addr = walk_addr;

    // Latch the range, advance the walk on each read, and capture the returned byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_addr <= '0;
            stop_addr <= '0;
            pending   <= 1'b0;
            pend_last <= 1'b0;
            nxt_byte  <= '0;
            nxt_last  <= 1'b0;
        end else begin
            if (init) begin
                walk_addr <= first_addr;
                stop_addr <= last_addr;
                pending   <= 1'b0;
            end else if (req) begin
                pend_last <= (walk_addr >= stop_addr);
                walk_addr <= walk_addr + ADDR_W'(1);
                pending   <= 1'b1;
            end else if (pending) begin
                nxt_byte  <= rd_data;
                nxt_last  <= pend_last;
                pending   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tfw_sequencer.sv
// Sequencer: steps through leader, start marker and data bits. It picks the length
// of each next phase and asks the fetcher for the following byte during the last bit.
// Assumes every phase length is >= 2 clocks, so a fetched byte is staged before it is needed.
module tfw_sequencer
    import tfw_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          CNT_W      = 15,
    parameter int unsigned LEADER_CYC = 9804,
    parameter int unsigned LEAD_LONG  = 28250,
    parameter int unsigned LEAD_SHORT = 22750,
    parameter int unsigned MARK_SHORT = 19250,
    parameter int unsigned MARK_NORM  = 22750,
    parameter int unsigned ZERO_PH    = 12500,
    parameter int unsigned ONE_PH     = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              expire,
    input  logic [DATA_W-1:0] nxt_byte,
    input  logic              nxt_last,
    output logic              load,
    output logic [CNT_W-1:0]  len,
    output logic              init,
    output logic              req,
    output logic              busy,
    output logic              done
);
    localparam int LC_W  = (LEADER_CYC > 1) ? $clog2(LEADER_CYC) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [LC_W-1:0]  LAST_LC  = LC_W'(LEADER_CYC - 1);

    tfw_state_e        st, st_n;
    logic              ph, ph_n;
    logic [LC_W-1:0]   lc, lc_n;
    logic [BIT_W-1:0]  bi, bi_n;
    logic [DATA_W-1:0] sh, sh_n;
    logic              cur_last, last_n;
    logic              done_n;

    // Phase length for one half of a data bit.
    function automatic logic [CNT_W-1:0] bit_len(input logic b);
        return b ? CNT_W'(ONE_PH) : CNT_W'(ZERO_PH);
    endfunction

    assign busy = (st != ST_IDLE);

    // Decide the next step at each phase boundary.
    always_comb begin
        st_n   = st;
        ph_n   = ph;
        lc_n   = lc;
        bi_n   = bi;
        sh_n   = sh;
        last_n = cur_last;
        done_n = 1'b0;
        load   = 1'b0;
        len    = '0;
        init   = 1'b0;
        req    = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    st_n = ST_LEAD;
                    ph_n = 1'b0;
                    lc_n = '0;
                    load = 1'b1;
                    len  = CNT_W'(LEAD_LONG);
                    init = 1'b1;
                end
            end
            ST_LEAD: begin
                if (expire) begin
                    load = 1'b1;
                    if (!ph) begin
                        ph_n = 1'b1;
                        len  = CNT_W'(LEAD_SHORT);
                    end else if (lc == LAST_LC) begin
                        st_n = ST_MARK;
                        ph_n = 1'b0;
                        len  = CNT_W'(MARK_SHORT);
                    end else begin
                        lc_n = lc + LC_W'(1);
                        ph_n = 1'b0;
                        len  = CNT_W'(LEAD_LONG);
                    end
                end
            end
            ST_MARK: begin
                if (expire) begin
                    load = 1'b1;
                    if (!ph) begin
                        ph_n = 1'b1;
                        len  = CNT_W'(MARK_NORM);
                        req  = 1'b1;
                    end else begin
                        st_n   = ST_DATA;
                        ph_n   = 1'b0;
                        bi_n   = '0;
                        sh_n   = nxt_byte;
                        last_n = nxt_last;
                        len    = bit_len(nxt_byte[DATA_W-1]);
                    end
                end
            end
            ST_DATA: begin
                if (expire) begin
                    if (!ph) begin
                        load = 1'b1;
                        ph_n = 1'b1;
                        len  = bit_len(sh[DATA_W-1]);
                        req  = (bi == LAST_BIT) && !cur_last;
                    end else if (bi != LAST_BIT) begin
                        load = 1'b1;
                        ph_n = 1'b0;
                        bi_n = bi + BIT_W'(1);
                        sh_n = {sh[DATA_W-2:0], 1'b0};
                        len  = bit_len(sh[DATA_W-2]);
                    end else if (!cur_last) begin
                        load   = 1'b1;
                        ph_n   = 1'b0;
                        bi_n   = '0;
                        sh_n   = nxt_byte;
                        last_n = nxt_last;
                        len    = bit_len(nxt_byte[DATA_W-1]);
                    end else begin
                        st_n   = ST_IDLE;
                        done_n = 1'b1;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Register the sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ph       <= 1'b0;
            lc       <= '0;
            bi       <= '0;
            sh       <= '0;
            cur_last <= 1'b0;
            done     <= 1'b0;
        end else begin
            st       <= st_n;
            ph       <= ph_n;
            lc       <= lc_n;
            bi       <= bi_n;
            sh       <= sh_n;
            cur_last <= last_n;
            done     <= done_n;
        end
    end
endmodule

// File: rtl/tape_fsk_writer.sv
// Cassette FSK tape writer top. It ties the sequencer, phase timer and byte fetcher
// together and owns the toggle-only tape flop.
// Assumes a synchronous memory with one cycle of read latency, and phase lengths >= 2 clocks.
module tape_fsk_writer
    import tfw_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int unsigned LEADER_CYC = 9804,
    parameter int unsigned LEAD_LONG  = 28250,
    parameter int unsigned LEAD_SHORT = 22750,
    parameter int unsigned MARK_SHORT = 19250,
    parameter int unsigned MARK_NORM  = 22750,
    parameter int unsigned ZERO_PH    = 12500,
    parameter int unsigned ONE_PH     = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              tape_out
);
    localparam int unsigned MAX_PH = max_u(max_u(max_u(LEAD_LONG, LEAD_SHORT),
                                                 max_u(MARK_SHORT, MARK_NORM)),
                                           max_u(ZERO_PH, ONE_PH));
    localparam int CNT_W = $clog2(MAX_PH + 1);

    logic              load, expire, init, req, nxt_last;
    logic [CNT_W-1:0]  len;
    logic [DATA_W-1:0] nxt_byte;

    tfw_sequencer #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .LEADER_CYC(LEADER_CYC),
        .LEAD_LONG(LEAD_LONG), .LEAD_SHORT(LEAD_SHORT),
        .MARK_SHORT(MARK_SHORT), .MARK_NORM(MARK_NORM),
        .ZERO_PH(ZERO_PH), .ONE_PH(ONE_PH)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .expire(expire),
        .nxt_byte(nxt_byte), .nxt_last(nxt_last),
        .load(load), .len(len), .init(init), .req(req),
        .busy(busy), .done(done)
    );

    tfw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .len(len), .expire(expire)
    );

    tfw_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .init(init),
        .first_addr(start_addr), .last_addr(end_addr),
        .req(req), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .nxt_byte(nxt_byte), .nxt_last(nxt_last)
    );

    // Flip the tape line at every phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      tape_out <= 1'b0;
        else if (expire) tape_out <= ~tape_out;
    end
endmodule

// File: rtl/tfw_checker.sv
// Cycle-level protocol checks for the tape writer, attached by bind.
// Assumes configured phase lengths of at least 2 clocks.
module tfw_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic rd_en,
    input logic tape_out
);
    // R2: an idle start always opens a transmission
    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10: the line moves only when the previous cycle was busy
    assert_toggle_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tape_out != $past(tape_out)) |-> $past(busy));

    // R10: no two level changes on consecutive clocks
    assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tape_out != $past(tape_out)) |=> $stable(tape_out));

    // R9: done is a lone pulse outside busy
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R9: busy only falls together with done
    assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: memory is read only during a transmission
    assert_read_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);
endmodule

bind tape_fsk_writer tfw_checker u_tfw_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .rd_en(rd_en), .tape_out(tape_out)
);

// File: tb/tape_fsk_writer_tb.sv
// Bench for tape_fsk_writer: it measures every interval between level changes and
// compares them with a phase sequence built from the bench's own memory image.
module tape_fsk_writer_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int LC = 3;
    localparam int LL = 7;
    localparam int LS = 6;
    localparam int MS = 4;
    localparam int MN = 6;
    localparam int ZP = 3;
    localparam int OP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] end_addr = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          busy, done, tape_out;

    tape_fsk_writer #(
        .ADDR_W(AW), .DATA_W(DW), .LEADER_CYC(LC), .LEAD_LONG(LL), .LEAD_SHORT(LS),
        .MARK_SHORT(MS), .MARK_NORM(MN), .ZERO_PH(ZP), .ONE_PH(OP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .end_addr(end_addr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .tape_out(tape_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    logic [DW-1:0] mem [0:255];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail = 0;

    // recorded activity
    int   edge_t [0:2047];
    int   n_edge = 0;
    int   rd_log [0:511];
    int   n_rd = 0;
    int   done_t = 0;
    int   n_done = 0;
    logic prev_tape = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tape_out !== prev_tape && n_edge < 2048) begin
                edge_t[n_edge] = cyc;
                n_edge = n_edge + 1;
            end
            prev_tape = tape_out;
            if (rd_en && n_rd < 512) begin
                rd_log[n_rd] = int'(rd_addr);
                n_rd = n_rd + 1;
            end
            if (done) begin
                done_t = cyc;
                n_done = n_done + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // expected sequences
    int exp_len [0:2047];
    int n_exp;
    int exp_addr [0:255];
    int n_bytes;

    function automatic void build_expect(input int s, input int e);
        int a;
        n_exp = 0;
        n_bytes = 0;
        for (int c = 0; c < LC; c++) begin
            exp_len[n_exp] = LL; exp_len[n_exp+1] = LS; n_exp += 2;
        end
        exp_len[n_exp] = MS; exp_len[n_exp+1] = MN; n_exp += 2;
        a = s;
        for (int k = 0; k < 256; k++) begin
            exp_addr[n_bytes] = a;
            n_bytes++;
            for (int b = DW - 1; b >= 0; b--) begin
                int l;
                l = mem[a][b] ? OP : ZP;
                exp_len[n_exp] = l; exp_len[n_exp+1] = l; n_exp += 2;
            end
            if (a >= e) break;
            a = (a + 1) % 256;
        end
    endfunction

    task automatic run_case(input int s, input int e, input bit poke, input string cnt_tag);
        int acc, guard, base_edges, bad_lead, bad_mark, bad_data, bad_rd, prv;
        build_expect(s, e);
        @(negedge clk);
        n_edge = 0; n_rd = 0; n_done = 0;
        start_addr = AW'(s); end_addr = AW'(e); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        acc = cyc;
        check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (25) @(negedge clk);
            start_addr = AW'($urandom % 256); end_addr = AW'($urandom % 256); start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (n_done == 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(n_done == 1, "R9", "done seen", n_done, 1);
        base_edges = n_edge;
        repeat (6) @(negedge clk);
        check(n_done == 1 && busy === 1'b0, "R9", "single done pulse, busy low", n_done, 1);
        check(n_edge == base_edges, "R9", "line holds while idle", n_edge, base_edges);
        check(n_edge == n_exp, "R6", "phase count (no trailer)", n_edge, n_exp);
        bad_lead = 0; bad_mark = 0; bad_data = 0;
        prv = acc;
        for (int i = 0; i < n_edge && i < n_exp; i++) begin
            if (edge_t[i] - prv != exp_len[i]) begin
                if (i < 2 * LC) bad_lead++;
                else if (i < 2 * LC + 2) bad_mark++;
                else bad_data++;
            end
            prv = edge_t[i];
        end
        check(bad_lead == 0, "R3", "leader phase mismatches", bad_lead, 0);
        check(bad_mark == 0, "R4", "marker phase mismatches", bad_mark, 0);
        check(bad_data == 0, "R5", "data phase mismatches", bad_data, 0);
        if (n_edge > 0)
            check(done_t == edge_t[n_edge-1], "R9", "done on final edge", done_t, edge_t[n_edge-1]);
        check(n_rd == n_bytes, cnt_tag, "bytes read", n_rd, n_bytes);
        bad_rd = 0;
        for (int i = 0; i < n_rd && i < n_bytes; i++)
            if (rd_log[i] != exp_addr[i]) bad_rd++;
        check(bad_rd == 0, "R8", "read address order", bad_rd, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int s, e;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = DW'($urandom);
        mem[10] = 8'h00; mem[11] = 8'hFF; mem[12] = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(tape_out === 1'b0, "R1", "tape_out after reset", int'(tape_out), 0);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", int'(busy), 0);
        check(rd_en === 1'b0, "R1", "rd_en after reset", int'(rd_en), 0);

        run_case(10, 12, 1'b0, "R6");     // all-zero, all-one, mixed bytes
        run_case(40, 40, 1'b0, "R6");     // single-byte range
        run_case(90, 80, 1'b0, "R7");     // reversed range sends one byte
        run_case(252, 255, 1'b0, "R6");   // range at top of memory
        run_case(20, 23, 1'b1, "R2");     // start during busy ignored
        for (int k = 0; k < 6; k++) begin
            s = int'($urandom % 250);
            e = s + int'($urandom % 6);
            run_case(s, e, 1'b0, "R6");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule